// File: doc/BRIEF.md
# Single-Precision Rounding Packer

The block takes a floating-point value held in an unpacked working form and packs it into a 32-bit IEEE 754 single-precision word. The unpacked value has these parts:

- a sign bit;
- a class code;
- a signed unbiased exponent;
- a mantissa with an explicit leading one, whose two lowest bits are the guard and round bits;
- a separate sticky bit.

The block rounds the value under one of four rounding modes. It produces subnormal results when the value is too small for a normal encoding. It saturates to infinity or to the largest finite value when the value is too large. It raises the inexact, underflow and overflow exception flags.

An arithmetic unit uses the block as its final stage. The unit presents one value per cycle with `inValid` high. One clock later the block registers the packed word and the three flags, and raises `outValid`. The flags always describe the word delivered in the same cycle. Trap delivery is left to the surrounding unit. The block only uses the underflow-trap enable to decide when to raise the underflow flag.

Top module: `sp_round_pack`

## Requirements
- R1: After reset `outValid`, `packedWord` and all three flags are 0 until the first accepted input.
- R2: An input presented with `inValid` high produces its result exactly one clock later, with `outValid` high. `outValid` is low in the cycle after `inValid` was low.
- R3: Class code 0 (zero) packs as the sign alone. Class code 2 (infinity) packs as the sign, exponent field 255 and fraction 0. Neither raises a flag, whatever the rounding bits, sticky bit or trap enable.
- R4: Class codes 3 (quiet NaN) and 4 (signalling NaN) pack with exponent field 255. The fraction is the 23 mantissa bits just below the leading one (`inMant[24:2]` at default widths), with fraction bit 22 forced to 1 and the sign kept. No rounding is applied and no flag is raised.
- R5: For class code 1 (number), when guard (`inMant[1]`), round (`inMant[0]`) and sticky are all 0, the retained bits pass unchanged and inexact stays 0. Any of the three being set raises inexact.
- R6: Round-to-nearest (mode code 0) increments only when guard is set and at least one of round, sticky or the retained LSB is set. A tie therefore goes to the even value.
- R7: Mode code 1 (toward zero) never increments. Mode code 2 (toward plus infinity) increments an inexact value only when it is positive. Mode code 3 (toward minus infinity) increments an inexact value only when it is negative.
- R8: When a normal value's increment carries the significand to 2.0, the exponent field rises by one and the fraction becomes 0.
- R9: When the biased exponent (unbiased plus 127) is 0 or below, the significand is shifted right by 1 minus the biased exponent before rounding. Shifted-out bits fold into sticky. The result packs with exponent field 0, or as the smallest normal (exponent field 1, fraction 0) when rounding reaches the implied-one position.
- R10: Underflow is raised only for a result that stays subnormal, and then only when that result is inexact or `ufTrapEn` is 1.
- R11: When the biased exponent after rounding is 255 or more, overflow and inexact are both raised. The word is signed infinity for mode 0, for mode 2 with a positive sign and for mode 3 with a negative sign. Otherwise it is the signed largest finite value (exponent field 254, fraction all ones).
- R12: Bit 31 of every packed word equals the input sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input value present this cycle |
| inSign | input | 1 | Sign of the value, 1 = negative |
| inClass | input | 3 | 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| inExp | input | 10 | Signed unbiased exponent of the leading one |
| inMant | input | 26 | Leading one at bit 25, fraction 24..2, guard bit 1, round bit 0 |
| inSticky | input | 1 | OR of all bits below the round bit |
| rndMode | input | 2 | 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| ufTrapEn | input | 1 | Underflow trap enabled |
| outValid | output | 1 | Packed result valid |
| packedWord | output | 32 | Packed single-precision word |
| flagInexact | output | 1 | Inexact exception |
| flagUnderflow | output | 1 | Underflow exception |
| flagOverflow | output | 1 | Overflow exception |

## Verification
The bound assertions watch, on every cycle, the properties that follow from the class and mode alone:

- the one-cycle latency;
- the sign passing through;
- the zero and NaN encodings;
- overflow never appearing without inexact, and never together with underflow;
- underflow appearing only on words with a zero exponent field;
- toward-zero rounding never producing infinity from a number.

Only the bench's directed vectors can show the exact rounding decisions: ties going to even, the directed modes near a tie, the carry into the exponent, the subnormal that rounds up to the smallest normal, and the choice between infinity and the largest finite value. These depend on specific mantissa bit patterns with known packed results.

// File: rtl/sp_pack_pkg.sv
package sp_pack_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } fpClass_e;

  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_ZERO = 2'd1,
    RND_UP   = 2'd2,
    RND_DOWN = 2'd3
  } rndMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic selZero;
    logic selInf;
    logic selNaN;
    logic selNum;
    logic doInc;
    logic toInf;
  } packCtl_t;

endpackage

// File: rtl/sp_pack_ctrl.sv
module sp_pack_ctrl
  import sp_pack_pkg::*;
(
  input  logic       inSign,
  input  logic [2:0] inClass,
  input  logic [1:0] rndMode,
  input  logic       guardBit,
  input  logic       roundBit,
  input  logic       stickyBit,
  input  logic       lsbBit,
  output packCtl_t   ctl
);

  fpClass_e cls;
  rndMode_e mode;
  logic     inexactRaw;
  logic     incNear;

  assign cls        = fpClass_e'(inClass);
  assign mode       = rndMode_e'(rndMode);
  assign inexactRaw = guardBit | roundBit | stickyBit;
  assign incNear    = guardBit & (roundBit | stickyBit | lsbBit);

  always_comb begin
    ctl = '0;
    unique case (cls)
      CLS_ZERO: ctl.selZero = 1'b1;
      CLS_NUM:  ctl.selNum  = 1'b1;
      CLS_INF:  ctl.selInf  = 1'b1;
      default:  ctl.selNaN  = 1'b1;
    endcase

    unique case (mode)
      RND_NEAR: begin
        ctl.doInc = incNear;
        ctl.toInf = 1'b1;
      end
      RND_ZERO: begin
        ctl.doInc = 1'b0;
        ctl.toInf = 1'b0;
      end
      RND_UP: begin
        ctl.doInc = inexactRaw & ~inSign;
        ctl.toInf = ~inSign;
      end
      default: begin
        ctl.doInc = inexactRaw & inSign;
        ctl.toInf = inSign;
      end
    endcase

    if (!ctl.selNum) ctl.doInc = 1'b0;
  end

endmodule

// File: rtl/sp_pack_dp.sv
module sp_pack_dp
  import sp_pack_pkg::*;
#(
  parameter int FRAC_W   = 23,
  parameter int EXP_W    = 8,
  parameter int MANT_W   = 26,
  parameter int EXP_IN_W = 10,
  localparam int WORD_W  = 1 + EXP_W + FRAC_W
)(
  input  logic                inSign,
  input  logic [EXP_IN_W-1:0] inExp,
  input  logic [MANT_W-1:0]   inMant,
  input  logic                inSticky,
  input  logic                ufTrapEn,
  input  packCtl_t            ctl,
  output logic                guardBit,
  output logic                roundBit,
  output logic                stickyBit,
  output logic                lsbBit,
  output logic [WORD_W-1:0]   wordNext,
  output logic                nxNext,
  output logic                ufNext,
  output logic                ofNext
);

  localparam int ALN_W = FRAC_W + 3;            // leading one, fraction, guard, round
  localparam int DROP  = MANT_W - ALN_W;
  localparam int BE_W  = EXP_IN_W + 2;
  localparam int SH_W  = $clog2(ALN_W + 1);
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX  = (1 << EXP_W) - 1;
  localparam logic signed [BE_W-1:0] BIAS_S = BE_W'(BIAS);
  localparam logic signed [BE_W-1:0] EMAX_S = BE_W'(EMAX);
  localparam logic signed [BE_W-1:0] ALN_S  = BE_W'(ALN_W);
  localparam logic signed [BE_W-1:0] ONE_S  = BE_W'(1);

  logic [ALN_W-1:0]         aligned;
  logic                     dropSticky;
  logic signed [BE_W-1:0]   biasedExp;
  logic signed [BE_W-1:0]   subShift;
  logic                     tiny;
  logic [SH_W-1:0]          shAmt;
  logic [2*ALN_W-1:0]       wide;
  logic [ALN_W-1:0]         rsVec;
  logic [FRAC_W:0]          keep;
  logic [FRAC_W+1:0]        rounded;
  logic                     carry;
  logic signed [BE_W-1:0]   expOut;
  logic                     overflow;
  logic                     inexactRaw;
  logic [FRAC_W-1:0]        nanFrac;
  logic [WORD_W-2:0]        magInf;
  logic [WORD_W-2:0]        magMax;

  // Bring the mantissa to leading-one, fraction, guard, round
  generate
    if (DROP > 0) begin : g_drop
      assign aligned    = inMant[MANT_W-1 -: ALN_W];
      assign dropSticky = |inMant[DROP-1:0];
    end else begin : g_exact
      assign aligned    = inMant[ALN_W-1:0];
      assign dropSticky = 1'b0;
    end
  endgenerate

  assign biasedExp = $signed({{2{inExp[EXP_IN_W-1]}}, inExp}) + BIAS_S;
  assign tiny      = (biasedExp <= $signed(BE_W'(0)));
  assign subShift  = ONE_S - biasedExp;

  always_comb begin
    if (!tiny)                 shAmt = '0;
    else if (subShift > ALN_S) shAmt = SH_W'(ALN_W);
    else                       shAmt = subShift[SH_W-1:0];
  end

  assign wide       = {aligned, {ALN_W{1'b0}}} >> shAmt;
  assign rsVec      = wide[2*ALN_W-1:ALN_W];
  assign guardBit   = rsVec[1];
  assign roundBit   = rsVec[0];
  assign stickyBit  = inSticky | dropSticky | (|wide[ALN_W-1:0]);
  assign keep       = rsVec[ALN_W-1:2];
  assign lsbBit     = keep[0];
  assign inexactRaw = guardBit | roundBit | stickyBit;

  assign rounded  = {1'b0, keep} + {{(FRAC_W+1){1'b0}}, ctl.doInc};
  assign carry    = rounded[FRAC_W+1];
  assign expOut   = biasedExp + $signed({{(BE_W-1){1'b0}}, carry});
  assign overflow = ~tiny & (expOut >= EMAX_S);

  assign nanFrac = aligned[ALN_W-2 -: FRAC_W] | {1'b1, {(FRAC_W-1){1'b0}}};
  assign magInf  = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  assign magMax  = {{(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};

  always_comb begin
    wordNext = '0;
    nxNext   = 1'b0;
    ufNext   = 1'b0;
    ofNext   = 1'b0;
    if (ctl.selZero) begin
      wordNext = {inSign, {(WORD_W-1){1'b0}}};
    end else if (ctl.selInf) begin
      wordNext = {inSign, magInf};
    end else if (ctl.selNaN) begin
      wordNext = {inSign, {EXP_W{1'b1}}, nanFrac};
    end else if (ctl.selNum) begin
      if (tiny) begin
        wordNext = {inSign, {(EXP_W-1){1'b0}}, rounded[FRAC_W], rounded[FRAC_W-1:0]};
        nxNext   = inexactRaw;
        ufNext   = ~rounded[FRAC_W] & (inexactRaw | ufTrapEn);
      end else if (overflow) begin
        wordNext = {inSign, (ctl.toInf ? magInf : magMax)};
        nxNext   = 1'b1;
        ofNext   = 1'b1;
      end else begin
        wordNext = {inSign, expOut[EXP_W-1:0], rounded[FRAC_W-1:0]};
        nxNext   = inexactRaw;
      end
    end
  end

endmodule

// File: rtl/sp_round_pack.sv
module sp_round_pack
  import sp_pack_pkg::*;
#(
  parameter int FRAC_W   = 23,
  parameter int EXP_W    = 8,
  parameter int MANT_W   = 26,
  parameter int EXP_IN_W = 10,
  localparam int WORD_W  = 1 + EXP_W + FRAC_W
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  input  logic                inSign,
  input  logic [2:0]          inClass,
  input  logic [EXP_IN_W-1:0] inExp,
  input  logic [MANT_W-1:0]   inMant,
  input  logic                inSticky,
  input  logic [1:0]          rndMode,
  input  logic                ufTrapEn,
  output logic                outValid,
  output logic [WORD_W-1:0]   packedWord,
  output logic                flagInexact,
  output logic                flagUnderflow,
  output logic                flagOverflow
);

  packCtl_t          ctl;
  logic              guardBit, roundBit, stickyBit, lsbBit;
  logic [WORD_W-1:0] wordNext;
  logic              nxNext, ufNext, ofNext;

  sp_pack_ctrl i_ctrl (
    .inSign    (inSign),
    .inClass   (inClass),
    .rndMode   (rndMode),
    .guardBit  (guardBit),
    .roundBit  (roundBit),
    .stickyBit (stickyBit),
    .lsbBit    (lsbBit),
    .ctl       (ctl)
  );

  sp_pack_dp #(
    .FRAC_W   (FRAC_W),
    .EXP_W    (EXP_W),
    .MANT_W   (MANT_W),
    .EXP_IN_W (EXP_IN_W)
  ) i_dp (
    .inSign    (inSign),
    .inExp     (inExp),
    .inMant    (inMant),
    .inSticky  (inSticky),
    .ufTrapEn  (ufTrapEn),
    .ctl       (ctl),
    .guardBit  (guardBit),
    .roundBit  (roundBit),
    .stickyBit (stickyBit),
    .lsbBit    (lsbBit),
    .wordNext  (wordNext),
    .nxNext    (nxNext),
    .ufNext    (ufNext),
    .ofNext    (ofNext)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid      <= 1'b0;
      packedWord    <= '0;
      flagInexact   <= 1'b0;
      flagUnderflow <= 1'b0;
      flagOverflow  <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        packedWord    <= wordNext;
        flagInexact   <= nxNext;
        flagUnderflow <= ufNext;
        flagOverflow  <= ofNext;
      end
    end
  end

endmodule

// File: rtl/sp_round_pack_chk.sv
module sp_round_pack_chk #(
  parameter int FRAC_W = 23,
  parameter int EXP_W  = 8,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
)(
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic              inSign,
  input logic [2:0]        inClass,
  input logic [1:0]        rndMode,
  input logic              outValid,
  input logic [WORD_W-1:0] packedWord,
  input logic              flagInexact,
  input logic              flagUnderflow,
  input logic              flagOverflow
);

  logic [EXP_W-1:0] expField;
  assign expField = packedWord[WORD_W-2 -: EXP_W];

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  assert_sign_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> packedWord[WORD_W-1] == $past(inSign));

  assert_zero_pack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inClass == 3'd0) |=>
      (packedWord[WORD_W-2:0] == '0) && !flagInexact && !flagUnderflow && !flagOverflow);

  assert_nan_pack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && (inClass == 3'd3 || inClass == 3'd4)) |=>
      (expField == '1) && packedWord[FRAC_W-1] && !flagInexact && !flagUnderflow && !flagOverflow);

  assert_no_inf_toward_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inClass == 3'd1 && rndMode == 2'd1) |=> (expField != '1));

  assert_overflow_inexact_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && flagOverflow) |-> flagInexact);

  assert_underflow_zero_exp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && flagUnderflow) |-> (expField == '0) && !flagOverflow);

endmodule

bind sp_round_pack sp_round_pack_chk #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) i_chk (.*);

// File: tb/test_sp_round_pack.sv
module test_sp_round_pack;

  typedef struct {
    logic [31:0] word;
    logic        nx;
    logic        uf;
    logic        of;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        inSign = 1'b0;
  logic [2:0]  inClass = 3'd0;
  logic [9:0]  inExp = '0;
  logic [25:0] inMant = '0;
  logic        inSticky = 1'b0;
  logic [1:0]  rndMode = 2'd0;
  logic        ufTrapEn = 1'b0;
  logic        outValid;
  logic [31:0] packedWord;
  logic        flagInexact, flagUnderflow, flagOverflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  expItem_t q[$];

  localparam logic [25:0] ONE = 26'h2000000;

  always #5 clk = ~clk;

  sp_round_pack i_sp_round_pack (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inSign(inSign),
    .inClass(inClass), .inExp(inExp), .inMant(inMant), .inSticky(inSticky),
    .rndMode(rndMode), .ufTrapEn(ufTrapEn), .outValid(outValid),
    .packedWord(packedWord), .flagInexact(flagInexact),
    .flagUnderflow(flagUnderflow), .flagOverflow(flagOverflow)
  );

  task automatic send(input logic s, input logic [2:0] c, input int e,
                      input logic [25:0] m, input logic st, input logic [1:0] md,
                      input logic tr, input logic [31:0] w, input logic nx,
                      input logic uf, input logic of, input string tag);
    expItem_t it;
    @(negedge clk);
    inValid = 1'b1; inSign = s; inClass = c; inExp = e[9:0];
    inMant = m; inSticky = st; rndMode = md; ufTrapEn = tr;
    it.word = w; it.nx = nx; it.uf = uf; it.of = of; it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && outValid) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected result: got %h expected none", packedWord);
      end else begin
        expItem_t it;
        it = q.pop_front();
        if (packedWord !== it.word || flagInexact !== it.nx ||
            flagUnderflow !== it.uf || flagOverflow !== it.of) begin
          fails++;
          $display("FAIL %s: got %h nx%b uf%b of%b expected %h nx%b uf%b of%b",
                   it.tag, packedWord, flagInexact, flagUnderflow, flagOverflow,
                   it.word, it.nx, it.uf, it.of);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || packedWord !== 32'h0 || flagInexact !== 1'b0 ||
        flagUnderflow !== 1'b0 || flagOverflow !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset state: got v%b %h expected v0 00000000", outValid, packedWord);
    end

    // R5 exact values
    send(0, 1, 0, ONE, 0, 0, 0, 32'h3F800000, 0, 0, 0, "R5 exact 1.0");
    send(1, 1, 0, 26'h3000000, 0, 0, 1, 32'hBFC00000, 0, 0, 0, "R5 R12 exact -1.5");
    // R6 nearest-even
    send(0, 1, 0, ONE | 26'h2, 0, 0, 0, 32'h3F800000, 1, 0, 0, "R6 tie to even stays");
    send(0, 1, 0, ONE | 26'h6, 0, 0, 0, 32'h3F800002, 1, 0, 0, "R6 tie odd rounds up");
    send(0, 1, 0, ONE | 26'h2, 1, 0, 0, 32'h3F800001, 1, 0, 0, "R6 guard plus sticky");
    send(0, 1, 0, ONE | 26'h1, 0, 0, 0, 32'h3F800000, 1, 0, 0, "R6 round only");
    // R7 directed modes
    send(0, 1, 0, ONE | 26'h3, 0, 1, 0, 32'h3F800000, 1, 0, 0, "R7 toward zero");
    send(0, 1, 0, ONE | 26'h1, 0, 2, 0, 32'h3F800001, 1, 0, 0, "R7 plus-inf positive");
    send(1, 1, 0, ONE | 26'h1, 0, 2, 0, 32'hBF800000, 1, 0, 0, "R7 plus-inf negative");
    send(1, 1, 0, ONE | 26'h1, 0, 3, 0, 32'hBF800001, 1, 0, 0, "R7 minus-inf negative");
    send(0, 1, 0, ONE, 1, 3, 0, 32'h3F800000, 1, 0, 0, "R7 minus-inf positive");
    // R8 carry into exponent
    send(0, 1, 0, 26'h3FFFFFE, 0, 0, 0, 32'h40000000, 1, 0, 0, "R8 carry to 2.0");
    // R11 overflow
    send(0, 1, 127, 26'h3FFFFFE, 0, 0, 0, 32'h7F800000, 1, 0, 1, "R11 carry overflow nearest");
    send(0, 1, 128, ONE, 0, 1, 0, 32'h7F7FFFFF, 1, 0, 1, "R11 toward zero max");
    send(0, 1, 128, ONE, 0, 0, 0, 32'h7F800000, 1, 0, 1, "R11 nearest inf");
    send(1, 1, 128, ONE, 0, 2, 0, 32'hFF7FFFFF, 1, 0, 1, "R11 plus-inf negative max");
    send(1, 1, 128, ONE, 0, 3, 0, 32'hFF800000, 1, 0, 1, "R11 minus-inf negative inf");
    send(0, 1, 300, ONE, 0, 2, 0, 32'h7F800000, 1, 0, 1, "R11 large exponent");
    send(0, 1, 127, 26'h3FFFFFC, 0, 0, 1, 32'h7F7FFFFF, 0, 0, 0, "R10 largest normal no underflow");
    // R9 / R10 subnormal
    send(0, 1, -127, ONE, 0, 0, 0, 32'h00400000, 0, 0, 0, "R9 exact subnormal");
    send(0, 1, -127, ONE, 0, 0, 1, 32'h00400000, 0, 1, 0, "R10 trap forces underflow");
    send(0, 1, -149, ONE, 0, 0, 0, 32'h00000001, 0, 0, 0, "R9 smallest subnormal");
    send(0, 1, -150, ONE, 0, 0, 0, 32'h00000000, 1, 1, 0, "R10 tie to zero");
    send(0, 1, -150, ONE, 0, 2, 0, 32'h00000001, 1, 1, 0, "R10 plus-inf subnormal");
    send(0, 1, -127, 26'h3FFFFFC, 0, 0, 1, 32'h00800000, 1, 0, 0, "R9 round to smallest normal");
    send(0, 1, -400, ONE, 0, 2, 0, 32'h00000001, 1, 1, 0, "R9 deep shift sticky");
    send(1, 1, -400, ONE, 0, 2, 0, 32'h80000000, 1, 1, 0, "R9 R12 deep shift negative");
    // R3 / R4 special classes
    send(1, 0, 5, ONE | 26'h3, 1, 2, 1, 32'h80000000, 0, 0, 0, "R3 negative zero");
    send(0, 2, 5, ONE | 26'h3, 1, 0, 1, 32'h7F800000, 0, 0, 0, "R3 infinity");
    send(0, 3, 0, ONE | (26'h123456 << 2) | 26'h3, 1, 0, 1, 32'h7FD23456, 0, 0, 0, "R4 quiet NaN");
    send(1, 4, 0, ONE | (26'h000001 << 2), 0, 2, 0, 32'hFFC00001, 0, 0, 0, "R4 signalling NaN");

    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    // R2: idle cycle leaves outValid low
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      fails++;
      $display("FAIL R2 idle: got %b expected 0", outValid);
    end
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R2 missing results: got %0d pending expected 0", q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule